// File: doc/BRIEF.md
# Pipelined Binary64 Divider Datapath

This block divides one binary64 operand by another in a fixed-latency pipeline meant to sit among other floating-point stages. Each cycle it can accept one operand pair, marked valid by `ready`. It splits each operand into sign, exponent and fraction and puts back the implicit leading one. The result sign and the provisional exponent are formed at once, and the two significands go into a chain of restoring quotient stages. A final stage normalises the quotient, rounds it under the per-operation mode bit and packs the word.

A valid bit and an exception bit travel with every slot, so `done` and `exc_out` stay lined up with the result they belong to. A zero divisor raises the exception at the divider. Otherwise the incoming exception bit is passed through unchanged. A single `stall` input freezes every stage at once, which puts a bubble into the surrounding pipeline. Subnormal operands, NaN, infinities and results whose exponent leaves the normal range are outside the block's scope.

Top module: `fp_div_pipe`

## Requirements
- R1: While `rst_n` is low, and after it is released until new operations arrive, `done` and `exc_out` are 0. A reset discards every operation in flight.
- R2: An operation accepted at a rising edge (`ready`=1, `stall`=0) presents `done`=1 with its result after exactly LATENCY (default 14) non-stalled rising edges, the accepting edge counted as the first. The block accepts one operation per cycle. `done` is 1 only for slots that entered with `ready` high.
- R3: While `stall` is high at a rising edge, no stage advances, `done`, `quotient` and `exc_out` keep their values, and `ready` and the operands are not taken in.
- R4: Bit 63 of the result is the XOR of bit 63 of the two operands, and this includes the zero-divisor and zero-dividend cases.
- R5: With `rnd_near`=1, the result for normal operands and a normal quotient is `dividend/divisor` rounded to nearest, with ties going to the even value.
- R6: With `rnd_near`=0, the result for normal operands and a normal quotient is `dividend/divisor` truncated toward zero.
- R7: The exponent field (bits 62:52) equals the dividend exponent minus the divisor exponent plus 1023. It is one lower when the dividend significand is smaller than the divisor significand, and one higher when rounding carries out of the significand.
- R8: When bits 62:0 of `divisor` are all zero, `exc_out` is 1 and the result has the computed sign, an exponent field of all ones and a zero fraction.
- R9: When the divisor is nonzero, `exc_out` equals the `exc_in` value that was sampled with the operation.
- R10: When the divisor is nonzero and bits 62:0 of `dividend` are all zero, the result is a zero carrying the computed sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| stall | input | 1 | Freezes all pipeline stages while high |
| ready | input | 1 | Marks the operand pair on the inputs as a valid operation |
| rnd_near | input | 1 | Rounding mode for this operation: 1 nearest-even, 0 truncate |
| exc_in | input | 1 | Exception flag arriving with the operands |
| dividend | input | 64 | Binary64 numerator |
| divisor | input | 64 | Binary64 denominator |
| done | output | 1 | Result on `quotient` is valid |
| quotient | output | 64 | Packed binary64 quotient |
| exc_out | output | 1 | Exception flag aligned with `quotient` |

## Verification
The bench builds the block with the default LATENCY of 14, so the format is binary64 and the quotient chain has twelve stages of four or five iterations each. The binary64 default lets the bench take its nearest-even reference from native double division. It computes truncated quotients with a single wide integer division. The mix of random stall and bubble patterns drives the valid and exception bits through every stage both while moving and while frozen. Directed pairs with equal significands and with the dividend significand below the divisor's cover both normalisation branches. A reset applied while operations are in flight shows that those operations are dropped.

// File: rtl/fp_div_pkg.sv
package fp_div_pkg;

  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned MANT_W = FRAC_W + 1;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  // quotient carries one bit above the leading one plus a guard bit
  localparam int unsigned QUO_W  = MANT_W + 2;
  localparam int unsigned REM_W  = MANT_W + 2;
  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef enum logic {
    RND_TRUNC = 1'b0,
    RND_NEAR  = 1'b1
  } rnd_e;

  typedef struct packed {
    logic              valid;
    logic              exc;
    rnd_e              rnd;
    logic              sign;
    logic              dvs_zero;
    logic              dvd_zero;
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] dvs;
    logic [REM_W-1:0]  rem;
    logic [QUO_W-1:0]  quo;
  } slot_t;

endpackage

// File: rtl/fp_div_unpack.sv
module fp_div_unpack
  import fp_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ready,
  input  logic              rnd_near,
  input  logic              exc_in,
  input  logic [WORD_W-1:0] dividend,
  input  logic [WORD_W-1:0] divisor,
  output slot_t             q
);

  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic              zb;
  slot_t             nxt;

  always_comb begin
    ea = dividend[WORD_W-2 -: EXP_W];
    eb = divisor[WORD_W-2 -: EXP_W];
    fa = dividend[FRAC_W-1:0];
    fb = divisor[FRAC_W-1:0];
    zb = (divisor[WORD_W-2:0] == '0);

    nxt          = '0;
    nxt.valid    = ready;
    nxt.exc      = ready & (exc_in | zb);
    nxt.rnd      = rnd_e'(rnd_near);
    nxt.sign     = dividend[WORD_W-1] ^ divisor[WORD_W-1];
    nxt.dvs_zero = zb;
    nxt.dvd_zero = (dividend[WORD_W-2:0] == '0);
    // modulo EXP_W: results outside the normal range are out of scope
    nxt.exp      = ea - eb + EXP_W'(BIAS);
    nxt.dvs      = {1'b1, fb};
    nxt.rem      = {2'b00, 1'b1, fa};
    nxt.quo      = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= nxt;
    end
  end

  a_r8_zero_flags_exc: assert property (@(posedge clk) disable iff (!rst_n)
    (q.valid && q.dvs_zero) |-> q.exc);

endmodule

// File: rtl/fp_div_rec_stage.sv
module fp_div_rec_stage
  import fp_div_pkg::*;
#(
  parameter int unsigned N_IT = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  slot_t d,
  output slot_t q
);

  logic [REM_W-1:0] r_w;
  logic [QUO_W-1:0] q_w;
  slot_t            nxt;

  always_comb begin
    r_w = d.rem;
    q_w = d.quo;
    for (int k = 0; k < N_IT; k++) begin
      if (r_w >= {2'b00, d.dvs}) begin
        r_w = r_w - {2'b00, d.dvs};
        q_w = {q_w[QUO_W-2:0], 1'b1};
      end else begin
        q_w = {q_w[QUO_W-2:0], 1'b0};
      end
      r_w = {r_w[REM_W-2:0], 1'b0};
    end
    nxt     = d;
    nxt.rem = r_w;
    nxt.quo = q_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= nxt;
    end
  end

  // partial remainder stays below twice the divisor after each stage (R5, R6)
  a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (q.valid && !q.dvs_zero) |-> (q.rem < {1'b0, q.dvs, 1'b0}));

endmodule

// File: rtl/fp_div_round.sv
module fp_div_round
  import fp_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  slot_t             d,
  output logic              done,
  output logic [WORD_W-1:0] result,
  output logic              exc_out
);

  logic              hi, guard, stk, up, carry;
  logic [MANT_W-1:0] mant;
  logic [MANT_W:0]   sum;
  logic [EXP_W-1:0]  xe;
  logic [WORD_W-1:0] res_nxt;

  always_comb begin
    hi    = d.quo[QUO_W-1];
    mant  = hi ? d.quo[QUO_W-1:2] : d.quo[QUO_W-2:1];
    guard = hi ? d.quo[1] : d.quo[0];
    stk   = (hi & d.quo[0]) | (d.rem != '0);
    up    = (d.rnd == RND_NEAR) & guard & (stk | mant[0]);
    sum   = {1'b0, mant} + (MANT_W+1)'(up);
    carry = sum[MANT_W];
    xe    = d.exp + {EXP_W{~hi}} + EXP_W'(carry);
    if (d.dvs_zero) begin
      res_nxt = {d.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (d.dvd_zero) begin
      res_nxt = {d.sign, {(WORD_W-1){1'b0}}};
    end else begin
      res_nxt = {d.sign, xe, sum[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      exc_out <= 1'b0;
      result  <= '0;
    end else if (en) begin
      done    <= d.valid;
      exc_out <= d.exc;
      result  <= res_nxt;
    end
  end

  // a quotient of two significands in [1,2) lies in (1/2,2): leading one in the top two bits (R7)
  a_r7_quot_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (d.valid && !d.dvs_zero) |-> (d.quo[QUO_W-1] | d.quo[QUO_W-2]));

  a_r6_final_rem: assert property (@(posedge clk) disable iff (!rst_n)
    (d.valid && !d.dvs_zero) |-> (d.rem < {1'b0, d.dvs, 1'b0}));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (!done && !exc_out);
    end
  end

endmodule

// File: rtl/fp_div_pipe.sv
module fp_div_pipe
  import fp_div_pkg::*;
#(
  parameter int unsigned LATENCY = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              ready,
  input  logic              rnd_near,
  input  logic              exc_in,
  input  logic [WORD_W-1:0] dividend,
  input  logic [WORD_W-1:0] divisor,
  output logic              done,
  output logic [WORD_W-1:0] quotient,
  output logic              exc_out
);

  // one unpack register, DIV_ST quotient registers, one round register
  localparam int unsigned DIV_ST = LATENCY - 2;

  logic  en;
  slot_t chain [DIV_ST+1];

  assign en = ~stall;

  fp_div_unpack u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ready    (ready),
    .rnd_near (rnd_near),
    .exc_in   (exc_in),
    .dividend (dividend),
    .divisor  (divisor),
    .q        (chain[0])
  );

  for (genvar s = 0; s < DIV_ST; s++) begin : g_rec
    localparam int unsigned LO = (s * QUO_W) / DIV_ST;
    localparam int unsigned HI = ((s + 1) * QUO_W) / DIV_ST;
    fp_div_rec_stage #(
      .N_IT (HI - LO)
    ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .d     (chain[s]),
      .q     (chain[s+1])
    );
  end

  fp_div_round u_round (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .d       (chain[DIV_ST]),
    .done    (done),
    .result  (quotient),
    .exc_out (exc_out)
  );

  a_r3_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(done) && $stable(quotient) && $stable(exc_out)));

  a_r2_done_needs_advance: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(stall));

endmodule

// File: tb/fp_div_pipe_tb.sv
module fp_div_pipe_tb_top;

  localparam int LAT = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        ready = 1'b0;
  logic        rnd_near = 1'b0;
  logic        exc_in = 1'b0;
  logic [63:0] dividend = '0;
  logic [63:0] divisor = '0;
  logic        done, exc_out;
  logic [63:0] quotient;

  always #10 clk = ~clk;

  fp_div_pipe #(.LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .ready(ready),
    .rnd_near(rnd_near), .exc_in(exc_in), .dividend(dividend),
    .divisor(divisor), .done(done), .quotient(quotient), .exc_out(exc_out)
  );

  int checks = 0;
  int errors = 0;
  bit over = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp_v, $time);
    end
  endtask

  function automatic logic [63:0] ref_div(input logic [63:0] a, input logic [63:0] b, input logic rn);
    logic [127:0] num, den, qq;
    logic [10:0]  e;
    logic         s;
    s = a[63] ^ b[63];
    if (b[62:0] == '0) return {s, 11'h7ff, 52'd0};
    if (a[62:0] == '0) return {s, 63'd0};
    if (rn) return $realtobits($bitstoreal(a) / $bitstoreal(b));
    num = {75'd0, 1'b1, a[51:0]} << 55;
    den = {75'd0, 1'b1, b[51:0]};
    qq  = num / den;
    e   = a[62:52] - b[62:52] + 11'd1023;
    if (qq[55]) return {s, e, qq[54:3]};
    return {s, e - 11'd1, qq[53:2]};
  endfunction

  // reference pipeline: one slot per advancing edge
  logic        mv [LAT];
  logic [63:0] mr [LAT];
  logic        me [LAT];
  string       mt [LAT];
  string       mx [LAT];
  logic        last_stall = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        mv[i] = 1'b0; mr[i] = '0; me[i] = 1'b0; mt[i] = "R2"; mx[i] = "R9";
      end
      last_stall = 1'b0;
    end else begin
      last_stall = stall;
      if (!stall) begin
        for (int i = LAT - 1; i > 0; i--) begin
          mv[i] = mv[i-1]; mr[i] = mr[i-1]; me[i] = me[i-1];
          mt[i] = mt[i-1]; mx[i] = mx[i-1];
        end
        mv[0] = ready;
        mr[0] = ref_div(dividend, divisor, rnd_near);
        me[0] = ready & (exc_in | (divisor[62:0] == '0));
        mx[0] = (divisor[62:0] == '0) ? "R8" : "R9";
        if (divisor[62:0] == '0)       mt[0] = "R8";
        else if (dividend[62:0] == '0) mt[0] = "R10";
        else if (rnd_near)             mt[0] = "R5";
        else                           mt[0] = "R6";
      end
    end
  end

  logic        pv_done, pv_exc, have_prev = 1'b0;
  logic [63:0] pv_res;

  always @(negedge clk) begin
    if (rst_n && !over) begin
      chk(done == mv[LAT-1], "R2 done", {63'd0, done}, {63'd0, mv[LAT-1]});
      if (done && mv[LAT-1]) begin
        chk(quotient[63] == mr[LAT-1][63], "R4 sign", quotient, mr[LAT-1]);
        chk(quotient[62:52] == mr[LAT-1][62:52], "R7 exponent", quotient, mr[LAT-1]);
        chk(quotient[51:0] == mr[LAT-1][51:0], mt[LAT-1], quotient, mr[LAT-1]);
        chk(exc_out == me[LAT-1], mx[LAT-1], {63'd0, exc_out}, {63'd0, me[LAT-1]});
      end
      if (last_stall && have_prev) begin
        chk(done == pv_done && quotient == pv_res && exc_out == pv_exc,
            "R3 hold", quotient, pv_res);
      end
    end
    pv_done = done; pv_res = quotient; pv_exc = exc_out; have_prev = rst_n;
  end

  task automatic put(input logic [63:0] a, input logic [63:0] b, input logic rn, input logic ex);
    @(negedge clk);
    dividend = a; divisor = b; rnd_near = rn; exc_in = ex; ready = 1'b1; stall = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ready = 1'b0; stall = 1'b0; exc_in = 1'b0;
    end
  endtask

  function automatic logic [63:0] rnd_op();
    logic [31:0] lo, hi;
    int unsigned ex;
    lo = $urandom; hi = $urandom;
    ex = 900 + ($urandom % 250);
    return {hi[31], 11'(ex), hi[19:0], lo};
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 150000);
    over = 1;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !exc_out, "R1 reset idle", {62'd0, done, exc_out}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk(!done && !exc_out, "R1 after release", {62'd0, done, exc_out}, 64'd0);

    // directed pairs, both modes
    for (int m = 0; m < 2; m++) begin
      put(64'h4018000000000000, 64'h4008000000000000, m[0], 1'b0); // 6/3
      put(64'hBFF0000000000000, 64'h4008000000000000, m[0], 1'b0); // -1/3
      put(64'h3FF0000000000000, 64'h3FF0000000000000, m[0], 1'b0); // 1/1
      put(64'h3FF8000000000000, 64'h3FE8000000000000, m[0], 1'b0); // 1.5/0.75
      put(64'h3FF0000000000000, 64'h3FFFFFFFFFFFFFFF, m[0], 1'b0); // below 1
      put(64'h4008000000000000, 64'h8000000000000000, m[0], 1'b0); // by -0
      put(64'h8000000000000000, 64'h4008000000000000, m[0], 1'b1); // -0/3, exc in
      put(64'h4000000000000000, 64'h3FF0000000000001, m[0], 1'b1); // exc in
    end
    idle(LAT + 2);

    // random traffic with bubbles and stalls
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      dividend = rnd_op();
      divisor  = rnd_op();
      if ($urandom % 25 == 0) divisor  = {divisor[63], 63'd0};
      if ($urandom % 25 == 0) dividend = {dividend[63], 63'd0};
      rnd_near = $urandom % 2;
      exc_in   = ($urandom % 8 == 0);
      ready    = ($urandom % 4 != 0);
      stall    = ($urandom % 6 == 0);
    end
    idle(LAT + 2);

    // reset while operations are in flight
    for (int i = 0; i < 6; i++) put(rnd_op(), rnd_op(), 1'b1, 1'b0);
    @(negedge clk); ready = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(!done && !exc_out, "R1 reset in flight", {62'd0, done, exc_out}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      chk(!done, "R1 flushed", {63'd0, done}, 64'd0);
    end

    over = 1;
    summary();
    $finish;
  end

endmodule